// File: doc/BRIEF.md
# Timeslot Interchange Switch Core

This block moves 16-bit samples between the 1024 channels of a time-division multiplexed stream, and any input channel can feed any output channel. Each channel occupies two clock cycles, so one frame is 2048 clocks long. A free-running timeslot counter writes each incoming sample into a data store at the entry for its channel. Frames alternate between two banks of that store. For each output timeslot, a per-slot control word is fetched from a connection store one channel early. The word gives the source channel, the output enable, a constant-message option and a frame-source mode.

A host fills the connection store through a plain address/data/strobe port. Each control word holds the source channel in bits 9:0, the output enable in bit 10, the message select in bit 11 and the frame-source mode in bit 12. Bits 15:13 are stored but never used. A frame pulse realigns the counter to slot 0. Without it, the counter wraps on its own every 2048 clocks.

Top module: `tsi_switch_core`

## Requirements
- R1: A frame pulse sampled high on a rising edge makes the next clock the first clock of slot 0. Without a pulse, the counter advances by one each clock and wraps after 2048 clocks. Slot d spans frame clocks 2d and 2d+1.
- R2: `din` is captured at the end of the first clock of slot n and stored at entry n of the bank for the current frame. The two banks swap at every frame start.
- R3: The control word for slot d is fetched during slot d-1, or during slot 1023 of the previous frame when d is 0. `dout` and `oe` are registered at the end of slot d-1. They hold steady for both clocks of slot d.
- R4: When bit 12 is 0 (previous-frame mode), `dout` for slot d is the sample that source channel bits 9:0 received in the previous frame.
- R5: When bit 12 is 1 (current-frame mode), `dout` is the sample that the source channel received earlier in the same frame. The source channel must be lower than d.
- R6: When bit 10 is 0, `oe` is 0 and `dout` is 0 for that slot. This overrides bits 11 and 12.
- R7: When bit 10 is 1 and bit 11 is 1, `dout` is bits 9:0 of the word, zero-extended, in place of stored data.
- R8: Bits 15:13 of a control word have no effect on the output.
- R9: A host write (`hwe`, `haddr`, `hwdata`, sampled on the rising edge) updates one entry. If the write lands before the fetch edge of that entry, it applies in the same frame. If it lands on the fetch edge itself, it applies from the next frame.
- R10: After reset, `dout` and `oe` are 0 and every connection entry is zero. Every slot therefore stays blanked until it is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp | input | 1 | Frame pulse; realigns the counter to slot 0 |
| din | input | 16 | Input sample for the current slot |
| hwe | input | 1 | Host write strobe |
| haddr | input | 10 | Host connection-entry address |
| hwdata | input | 16 | Host control word |
| dout | output | 16 | Switched output sample |
| oe | output | 1 | Output enable for the current slot |

## Verification
A counter or bank-select fault misroutes every switched slot within one frame. It shows up as samples carrying the wrong frame stamp or the wrong channel number on `dout`. A connection entry read one slot off, or a pipeline stage added or missing, moves every output by one channel. This shows at once, because each output slot has a distinct expected value. A broken write-collision rule or a stale connection word shows only on the slot involved and only in the frame after the write. The bench therefore checks the two frames that follow each timed write.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic {
    SRC_PREV_FRAME = 1'b0,
    SRC_THIS_FRAME = 1'b1
  } src_mode_e;

  // Bank to read for an output slot.
  // The fetch in the last slot of a frame serves slot 0 of the next frame,
  // so "previous" and "current" swap there.
  function automatic logic read_bank(input logic wr_bank,
                                     input logic last_slot,
                                     input src_mode_e mode);
    return wr_bank ^ last_slot ^ (mode == SRC_PREV_FRAME);
  endfunction

endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase #(
  parameter int CH_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp,
  output logic [CH_W-1:0] slot,
  output logic            phase,
  output logic            wr_bank,
  output logic            last_slot,
  output logic            frame_start
);
  localparam int CNT_W = CH_W + 1;

  logic [CNT_W-1:0] cnt_q;

  assign frame_start = fp || (cnt_q == '1);
  assign slot        = cnt_q[CNT_W-1:1];
  assign phase       = cnt_q[0];
  assign last_slot   = (slot == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wr_bank <= 1'b0;
    end else if (frame_start) begin
      cnt_q   <= '0;
      wr_bank <= ~wr_bank;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R1: a frame pulse realigns the counter to slot 0, phase 0
  p_fp_realign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (cnt_q == '0));

  // R1: without a frame start the counter steps by one
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: banks swap at every frame start
  p_bank_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (wr_bank != $past(wr_bank)));

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int CH_W   = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwe,
  input  logic [CH_W-1:0]   haddr,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              rd_stb,
  input  logic [CH_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] cw_q
);
  localparam int N = 1 << CH_W;

  logic [DATA_W-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (hwe) begin
      mem[haddr] <= hwdata;
    end
  end

  // Fetch takes the value held before this edge. A write on the same
  // edge therefore reaches the output one frame later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cw_q <= '0;
    else if (rd_stb) cw_q <= mem[rd_addr];
  end

  // R3: the fetched word changes only on a fetch strobe
  p_cw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(cw_q));

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int CH_W   = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_stb,
  input  logic              wr_bank,
  input  logic [CH_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_bank,
  input  logic [CH_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int N     = 1 << CH_W;
  localparam int BANKS = 2;

  logic [DATA_W-1:0] bank_rd [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] arr [N];
    always_ff @(posedge clk) begin
      if (wr_stb && (wr_bank == 1'(b))) arr[wr_addr] <= din;
    end
    assign bank_rd[b] = arr[rd_addr];
  end

  assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core #(
  parameter int CH_W   = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp,
  input  logic [DATA_W-1:0] din,
  input  logic              hwe,
  input  logic [CH_W-1:0]   haddr,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);
  import tsi_pkg::*;

  localparam int OE_BIT   = CH_W;
  localparam int MSG_BIT  = CH_W + 1;
  localparam int MODE_BIT = CH_W + 2;
  localparam int PAD_W    = DATA_W - CH_W;

  logic [CH_W-1:0]   slot;
  logic              phase, wr_bank, last_slot, frame_start;
  logic              dm_wr_stb, cw_rd_stb, out_ld_stb;
  logic [CH_W-1:0]   next_slot;
  logic [DATA_W-1:0] cw_q, rd_data;
  logic              rd_bank;
  src_mode_e         cw_mode;

  // Output word for one slot: {oe, dout}
  function automatic logic [DATA_W:0] build_out(input logic [DATA_W-1:0] cw,
                                                input logic [DATA_W-1:0] sample);
    if (!cw[OE_BIT])      return '0;
    else if (cw[MSG_BIT]) return {1'b1, {PAD_W{1'b0}}, cw[CH_W-1:0]};
    else                  return {1'b1, sample};
  endfunction

  tsi_timebase #(.CH_W(CH_W)) i_timebase (
    .clk(clk), .rst_n(rst_n), .fp(fp),
    .slot(slot), .phase(phase), .wr_bank(wr_bank),
    .last_slot(last_slot), .frame_start(frame_start)
  );

  // Data write and control fetch at the end of the first clock of a slot.
  // Output load at the end of the second clock.
  assign dm_wr_stb  = !phase;
  assign cw_rd_stb  = !phase;
  assign out_ld_stb = phase;
  assign next_slot  = slot + 1'b1;

  tsi_conn_mem #(.CH_W(CH_W), .DATA_W(DATA_W)) i_conn_mem (
    .clk(clk), .rst_n(rst_n),
    .hwe(hwe), .haddr(haddr), .hwdata(hwdata),
    .rd_stb(cw_rd_stb), .rd_addr(next_slot), .cw_q(cw_q)
  );

  assign cw_mode = src_mode_e'(cw_q[MODE_BIT]);
  assign rd_bank = read_bank(wr_bank, last_slot, cw_mode);

  tsi_data_mem #(.CH_W(CH_W), .DATA_W(DATA_W)) i_data_mem (
    .clk(clk), .wr_stb(dm_wr_stb), .wr_bank(wr_bank), .wr_addr(slot),
    .din(din), .rd_bank(rd_bank), .rd_addr(cw_q[CH_W-1:0]), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          {oe, dout} <= '0;
    else if (out_ld_stb) {oe, dout} <= build_out(cw_q, rd_data);
  end

  // R3: outputs change only at slot boundaries
  p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ld_stb |=> ($stable(dout) && $stable(oe)));

  // R6: enable follows the fetched word
  p_oe_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ld_stb |=> (oe == $past(cw_q[OE_BIT])));

  // R6: a blanked slot carries zero data
  p_blank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dout == '0));

  // R7: message slots carry the address field
  p_msg_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ld_stb && cw_q[OE_BIT] && cw_q[MSG_BIT]) |=>
      (dout == {{PAD_W{1'b0}}, $past(cw_q[CH_W-1:0])}));

  // R4: switched slots carry the data-store read
  p_switch_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ld_stb && cw_q[OE_BIT] && !cw_q[MSG_BIT]) |=> (dout == $past(rd_data)));

  // R8: the whole word, reserved bits included, is held between fetches
  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_rd_stb |=> $stable(cw_q));

  // R2: frame start lands on a slot boundary unless forced by the pulse
  p_frame_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fp) |-> (phase && last_slot));

endmodule

// File: tb/test_tsi_switch_core.sv
`timescale 1ns/1ps
module test_tsi_switch_core;
  localparam int FRAME = 2048;
  localparam int NFR   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp = 1'b0;
  logic [15:0] din = '0;
  logic        hwe = 1'b0;
  logic [9:0]  haddr = '0;
  logic [15:0] hwdata = '0;
  logic [15:0] dout;
  logic        oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic        eo;
    logic [15:0] ed;
    logic        so;
    logic [15:0] sd;
    int          f;
    int          d;
    int          tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  tsi_switch_core i_tsi_switch_core (
    .clk(clk), .rst_n(rst_n), .fp(fp), .din(din),
    .hwe(hwe), .haddr(haddr), .hwdata(hwdata), .dout(dout), .oe(oe)
  );

  function automatic logic [15:0] pat(input int f, input int ch);
    return {6'(f), 10'(ch)};
  endfunction

  function automatic logic [15:0] prog(input int d);
    logic [9:0] s1;
    s1 = 10'((1023 - d) ^ (d << 3));
    case (d % 8)
      0:       return 16'h0800 | 16'(d);                 // msg set, oe clear
      1:       return 16'h0C00 | 16'((d ^ 'h155) & 'h3FF);
      2:       return 16'h1400 | 16'(d - 1);
      3:       return 16'h1400 | 16'(d / 2);
      4:       return 16'hA400 | 16'(s1);                // reserved bits set
      default: return 16'h0400 | 16'(s1);
    endcase
  endfunction

  // Word in force for slot d of frame f
  function automatic logic [15:0] word_at(input int f, input int d);
    if (f == 0) return 16'h0000;
    if (d == 5 && f >= 4) return 16'h0EAB;
    if (d == 9 && f >= 3) return 16'h0809;
    return prog(d);
  endfunction

  function automatic int tag_of(input int f, input int d, input logic [15:0] w);
    if (f == 0) return 10;
    if ((d == 5 && f >= 3) || (d == 9 && f == 3)) return 9;
    if (!w[10]) return 6;
    if (w[11]) return 7;
    if (w[12]) return 5;
    if (w[15:13] != 0) return 8;
    return 4;
  endfunction

  function automatic string tag_name(input int t);
    case (t)
      10: return "R10 R1";
      9:  return "R9";
      6:  return "R6";
      7:  return "R7";
      5:  return "R5";
      8:  return "R8";
      default: return "R4 R2";
    endcase
  endfunction

  // Driver: feeds samples, performs host writes, pushes expected items
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (dout !== 16'h0 || oe !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset outputs: dout=%h oe=%b expected dout=0000 oe=0", dout, oe);
    end
    repeat (3) @(negedge clk);
    fp = 1'b1;
    for (int j = 0; j < NFR * FRAME; j++) begin
      @(negedge clk);
      fp = 1'b0;
      hwe = 1'b0;
      begin
        int f, s;
        logic [15:0] w;
        item_t it;
        f = j / FRAME;
        s = (j % FRAME) / 2;
        din = pat(f, s);
        if (j >= FRAME && j < FRAME + 1024) begin
          hwe = 1'b1; haddr = 10'(j - FRAME); hwdata = prog(j - FRAME);
        end
        if (j == 3 * FRAME + 8) begin          // same edge as fetch of entry 5
          hwe = 1'b1; haddr = 10'd5; hwdata = 16'h0EAB;
        end
        if (j == 3 * FRAME + 14) begin         // before fetch of entry 9
          hwe = 1'b1; haddr = 10'd9; hwdata = 16'h0809;
        end
        if ((j % 2) == 0 && f != 1) begin
          w = word_at(f, s);
          it.f = f; it.d = s; it.tag = tag_of(f, s, w);
          it.so = oe; it.sd = dout;
          if (!w[10])      begin it.eo = 1'b0; it.ed = 16'h0; end
          else if (w[11])  begin it.eo = 1'b1; it.ed = {6'h0, w[9:0]}; end
          else if (w[12])  begin it.eo = 1'b1; it.ed = pat(f, int'(w[9:0])); end
          else             begin it.eo = 1'b1; it.ed = pat(f - 1, int'(w[9:0])); end
          q.push_back(it);
        end
      end
    end
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  // Monitor: in the second clock of each slot, compares both clocks' outputs
  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_checks++;
      if (it.so !== it.eo || it.sd !== it.ed) begin
        n_fail++;
        $display("FAIL %s frame %0d slot %0d first clock: oe=%b dout=%h expected oe=%b dout=%h",
                 tag_name(it.tag), it.f, it.d, it.so, it.sd, it.eo, it.ed);
      end
      n_checks++;
      if (oe !== it.eo || dout !== it.ed) begin   // R3 hold over second clock
        n_fail++;
        $display("FAIL R3 %s frame %0d slot %0d second clock: oe=%b dout=%h expected oe=%b dout=%h",
                 tag_name(it.tag), it.f, it.d, oe, dout, it.eo, it.ed);
      end
    end
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: done=%b expected 1", done);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule